// File: doc/BRIEF.md
# Banked GPIO Controller with Masked Writes

This block controls 128 general-purpose pins arranged as four banks of 32. Each bank has its own register set: an output value register, two masked-write ports that change any chosen subset of one half-word in a single write, a direction register, a separate output-enable register, a synchronised readback of the pin inputs and a full set of per-pin interrupt controls. A bank can also be switched into bypass, where its pin outputs follow an external value instead of the output register.

Software talks to the block through a plain single-cycle register port. A write is taken on the rising clock edge whenever `bus_wr` is high, and read data is a combinational function of `bus_addr`. The port has no valid/ready handshake and never applies back-pressure: every access completes in the cycle it is presented. The address is a word address: bits [5:4] pick the bank and bits [3:0] pick the register. Per-pin interrupts are level or edge triggered, and edge mode can fire on rising edges, falling edges or both. The status and enable bits of all banks combine into one interrupt output. A handler reads each bank's status register to find the pending source.

Register offsets within a bank: 0 output value, 1 masked write low half, 2 masked write high half, 3 input readback, 4 direction, 5 output enable, 6 interrupt enable set, 7 interrupt enable clear, 8 trigger type, 9 polarity, 10 any-edge, 11 interrupt status, 12 bypass.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every register reads 0 (except level status, which follows the pins), `pin_out` and `pin_oe` are all 0 and `irq` is 0.
- R2: A write to offset 0 of a bank stores the word. With bypass off, that bank's 32 bits of `pin_out` show the stored word from the next cycle, and offset 0 reads it back.
- R3: A write to offset 1 (low half) or offset 2 (high half) treats write data bits [31:16] as a mask and bits [15:0] as data. Each output bit of that half whose mask bit is 0 takes the data bit. Each bit whose mask bit is 1 keeps its value. The other half is unchanged. Offsets 1 and 2 read as 0, and a masked write leaves `pin_oe` unchanged.
- R4: Offsets 4 (direction, 1 = output) and 5 (output enable) read back as written, and each `pin_oe` bit is high only when both its direction bit and its enable bit are 1.
- R5: Offset 3 returns the pin inputs of the bank after a two-flop synchroniser. A change on `pin_in` is visible on the second rising edge after it.
- R6: With trigger type 0 (level), a status bit reads 1 while the synchronised pin equals its polarity bit (1 = high, 0 = low). Writing 1 to it has no effect.
- R7: With trigger type 1 (edge) and any-edge 0, a status bit is set by a rising edge when polarity is 1, or by a falling edge when polarity is 0. It stays set until 1 is written to it at offset 11.
- R8: With trigger type 1 and any-edge 1, both rising and falling edges set the status bit, whatever the polarity.
- R9: Writing 1s to offset 6 enables those pins' interrupts, and writing 1s to offset 7 disables them. Both offsets read the enable mask. `irq` is high exactly when some bank has a status bit set whose enable bit is 1.
- R10: Writing 1 to bit 0 of offset 12 puts the bank in bypass. Its `pin_out` bits then follow `byp_in` combinationally, while the stored output value is kept and returns when bypass is cleared.
- R11: Writes affect only the bank selected by address bits [5:4]. The registers and pins of other banks keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Word address: bank in [5:4], register in [3:0] |
| bus_wr | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pin_in | input | 128 | Pin input levels, bank n in bits [32n+31:32n] |
| byp_in | input | 128 | External output values used by banks in bypass |
| pin_out | output | 128 | Pin output values |
| pin_oe | output | 128 | Pin output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `bus_addr` always names one of the four banks. They also assume that `byp_in` is the only input that moves `pin_out` without a register write, so any change in an output is traced either to a write or to a change in `byp_in`. The stimulus changes `pin_in` and `byp_in` only on falling edges, away from register writes. It holds each pin level for several cycles so that every edge passes cleanly through the synchroniser before the status is read.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int REG_W = 4;
  localparam logic [REG_W-1:0] OFS_DOUT = 4'd0;
  localparam logic [REG_W-1:0] OFS_MLO  = 4'd1;
  localparam logic [REG_W-1:0] OFS_MHI  = 4'd2;
  localparam logic [REG_W-1:0] OFS_DIN  = 4'd3;
  localparam logic [REG_W-1:0] OFS_DIR  = 4'd4;
  localparam logic [REG_W-1:0] OFS_OEN  = 4'd5;
  localparam logic [REG_W-1:0] OFS_IENS = 4'd6;
  localparam logic [REG_W-1:0] OFS_IENC = 4'd7;
  localparam logic [REG_W-1:0] OFS_TYPE = 4'd8;
  localparam logic [REG_W-1:0] OFS_POL  = 4'd9;
  localparam logic [REG_W-1:0] OFS_ANY  = 4'd10;
  localparam logic [REG_W-1:0] OFS_STAT = 4'd11;
  localparam logic [REG_W-1:0] OFS_BYP  = 4'd12;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_in,
  input  logic [W-1:0] edge_mode,
  input  logic [W-1:0] pol_hi,
  input  logic [W-1:0] both_edges,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] stat
);
  logic [W-1:0] prev_q;
  logic [W-1:0] sticky_q;
  logic [W-1:0] rise, fall, hit, lvl_match;

  always_comb begin
    rise      = lvl_in & ~prev_q;
    fall      = ~lvl_in & prev_q;
    hit       = (both_edges & (rise | fall)) |
                (~both_edges & ((pol_hi & rise) | (~pol_hi & fall)));
    lvl_match = ~(lvl_in ^ pol_hi);
    stat      = (edge_mode & sticky_q) | (~edge_mode & lvl_match);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      sticky_q <= '0;
    end else begin
      prev_q   <= lvl_in;
      sticky_q <= edge_mode & ((sticky_q & ~clr_bits) | hit);
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int PIN_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [REG_W-1:0]   ofs,
  input  logic [PIN_W-1:0]   wdata,
  output logic [PIN_W-1:0]   rdata,
  input  logic [PIN_W-1:0]   pins,
  input  logic [PIN_W-1:0]   byp_val,
  output logic [PIN_W-1:0]   pout,
  output logic [PIN_W-1:0]   poe,
  output logic [PIN_W-1:0]   pend,
  output logic               byp_on
);
  localparam int HALF = PIN_W / 2;

  logic [PIN_W-1:0] dout_q, dir_q, oen_q, ien_q, type_q, pol_q, any_q;
  logic             byp_q;
  logic [PIN_W-1:0] din_s, stat, clr_bits;
  logic [HALF-1:0]  mask_f, data_f;

  gpio_sync #(.W(PIN_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins), .q(din_s)
  );

  assign clr_bits = (we && ofs == OFS_STAT) ? wdata : '0;

  gpio_irq_unit #(.W(PIN_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .lvl_in(din_s), .edge_mode(type_q),
    .pol_hi(pol_q), .both_edges(any_q), .clr_bits(clr_bits), .stat(stat)
  );

  assign mask_f = wdata[PIN_W-1:HALF];
  assign data_f = wdata[HALF-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '0;
      oen_q  <= '0;
      ien_q  <= '0;
      type_q <= '0;
      pol_q  <= '0;
      any_q  <= '0;
      byp_q  <= 1'b0;
    end else if (we) begin
      case (ofs)
        OFS_DOUT: dout_q <= wdata;
        OFS_MLO:  dout_q[HALF-1:0] <= (dout_q[HALF-1:0] & mask_f) | (data_f & ~mask_f);
        OFS_MHI:  dout_q[PIN_W-1:HALF] <= (dout_q[PIN_W-1:HALF] & mask_f) | (data_f & ~mask_f);
        OFS_DIR:  dir_q  <= wdata;
        OFS_OEN:  oen_q  <= wdata;
        OFS_IENS: ien_q  <= ien_q | wdata;
        OFS_IENC: ien_q  <= ien_q & ~wdata;
        OFS_TYPE: type_q <= wdata;
        OFS_POL:  pol_q  <= wdata;
        OFS_ANY:  any_q  <= wdata;
        OFS_BYP:  byp_q  <= wdata[0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (ofs)
      OFS_DOUT: rdata = dout_q;
      OFS_DIN:  rdata = din_s;
      OFS_DIR:  rdata = dir_q;
      OFS_OEN:  rdata = oen_q;
      OFS_IENS: rdata = ien_q;
      OFS_IENC: rdata = ien_q;
      OFS_TYPE: rdata = type_q;
      OFS_POL:  rdata = pol_q;
      OFS_ANY:  rdata = any_q;
      OFS_STAT: rdata = stat;
      OFS_BYP:  rdata = {{(PIN_W-1){1'b0}}, byp_q};
      default:  rdata = '0;
    endcase
  end

  assign pout   = byp_q ? byp_val : dout_q;
  assign poe    = dir_q & oen_q;
  assign pend   = stat & ien_q;
  assign byp_on = byp_q;
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int PIN_W     = 32,
  parameter int ADDR_W    = 6,
  localparam int BANK_BITS = ADDR_W - REG_W,
  localparam int ALL_W     = NUM_BANKS * PIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [PIN_W-1:0]  bus_wdata,
  output logic [PIN_W-1:0]  bus_rdata,
  input  logic [ALL_W-1:0]  pin_in,
  input  logic [ALL_W-1:0]  byp_in,
  output logic [ALL_W-1:0]  pin_out,
  output logic [ALL_W-1:0]  pin_oe,
  output logic              irq
);
  logic [BANK_BITS-1:0] sel_bank;
  logic [REG_W-1:0]     sel_ofs;
  logic [PIN_W-1:0]     bank_rd [NUM_BANKS];
  logic [NUM_BANKS-1:0][PIN_W-1:0] bank_pend;
  logic [NUM_BANKS-1:0] byp_en_w;

  assign sel_bank = bus_addr[ADDR_W-1:REG_W];
  assign sel_ofs  = bus_addr[REG_W-1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_bank #(.PIN_W(PIN_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (bus_wr && sel_bank == BANK_BITS'(b)),
      .ofs     (sel_ofs),
      .wdata   (bus_wdata),
      .rdata   (bank_rd[b]),
      .pins    (pin_in[b*PIN_W +: PIN_W]),
      .byp_val (byp_in[b*PIN_W +: PIN_W]),
      .pout    (pin_out[b*PIN_W +: PIN_W]),
      .poe     (pin_oe[b*PIN_W +: PIN_W]),
      .pend    (bank_pend[b]),
      .byp_on  (byp_en_w[b])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (sel_bank == BANK_BITS'(b)) bus_rdata = bank_rd[b];
  end

  assign irq = |bank_pend;
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk
  import gpio_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int PIN_W     = 32,
  parameter int ADDR_W    = 6,
  localparam int BANK_BITS = ADDR_W - REG_W,
  localparam int ALL_W     = NUM_BANKS * PIN_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_wr,
  input logic [PIN_W-1:0]     bus_wdata,
  input logic [ALL_W-1:0]     byp_in,
  input logic [ALL_W-1:0]     pin_out,
  input logic [ALL_W-1:0]     pin_oe,
  input logic                 irq,
  input logic [NUM_BANKS-1:0] byp_en
);
  logic [BANK_BITS-1:0] wr_bank;
  logic [REG_W-1:0]     wr_ofs;
  logic [PIN_W-1:0]     out_slice [NUM_BANKS];

  assign wr_bank = bus_addr[ADDR_W-1:REG_W];
  assign wr_ofs  = bus_addr[REG_W-1:0];

  always_comb
    for (int b = 0; b < NUM_BANKS; b++) out_slice[b] = pin_out[b*PIN_W +: PIN_W];

  // R1: first cycle out of reset is quiet
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_out == '0 && pin_oe == '0 && !irq));

  // R2: a value written with bypass off appears on the bank's pins
  a_r2_dout_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && wr_ofs == OFS_DOUT && !byp_en[wr_bank])
      |=> out_slice[$past(wr_bank)] == $past(bus_wdata));

  // R3: masked writes never touch output enables
  a_r3_mask_keeps_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (wr_ofs == OFS_MLO || wr_ofs == OFS_MHI)) |=> $stable(pin_oe));

  // R10: without a write, outputs only move when the bypass source moves
  a_r10_out_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr) |=> ($stable(pin_out) || !$stable(byp_in)));
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(
  .NUM_BANKS(NUM_BANKS), .PIN_W(PIN_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .byp_in(byp_in), .pin_out(pin_out),
  .pin_oe(pin_oe), .irq(irq), .byp_en(byp_en_w)
);

// File: tb/gpio_bank_ctrl_test.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [5:0]   bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [127:0] pin_in = '0;
  logic [127:0] byp_in = '0;
  logic [127:0] pin_out, pin_oe;
  logic         irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  gpio_bank_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .byp_in(byp_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [5:0]  addr;
    logic [31:0] data;   // write data, or expected read data
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 6'h00, 32'hA5A5_0F0F, 4'd2},  // R2 write output value
    '{1'b0, 6'h00, 32'hA5A5_0F0F, 4'd2},  // R2 readback
    '{1'b1, 6'h01, 32'h00FF_1234, 4'd3},  // R3 low half: [15:8] written, [7:0] kept
    '{1'b0, 6'h00, 32'hA5A5_120F, 4'd3},
    '{1'b1, 6'h02, 32'hFF00_00C3, 4'd3},  // R3 high half: [23:16] written, [31:24] kept
    '{1'b0, 6'h00, 32'hA5C3_120F, 4'd3},
    '{1'b0, 6'h01, 32'h0000_0000, 4'd3},  // R3 masked port reads zero
    '{1'b1, 6'h10, 32'hDEAD_BEEF, 4'd11}, // R11 other bank
    '{1'b0, 6'h00, 32'hA5C3_120F, 4'd11},
    '{1'b0, 6'h10, 32'hDEAD_BEEF, 4'd11},
    '{1'b1, 6'h24, 32'hFFFF_0000, 4'd4},  // R4 direction
    '{1'b1, 6'h25, 32'h00FF_00FF, 4'd4},  // R4 output enable
    '{1'b0, 6'h24, 32'hFFFF_0000, 4'd4},
    '{1'b0, 6'h25, 32'h00FF_00FF, 4'd4}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_b3(input logic [31:0] v);
    @(negedge clk);
    pin_in[127:96] = v;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] rd;
    cycles(3);
    // R1: reset state
    check("R1 pin_out", pin_out[31:0] | pin_out[127:96], 32'h0);
    check("R1 pin_oe", pin_oe[31:0] | pin_oe[95:64], 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    @(negedge clk) rst_n = 1'b1;
    bus_read(6'h00, rd); check("R1 dout reg", rd, 32'h0);
    bus_read(6'h36, rd); check("R1 enable reg", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) bus_write(VECS[i].addr, VECS[i].data);
      else begin
        bus_read(VECS[i].addr, rd);
        check($sformatf("R%0d table %0d", VECS[i].req, i), rd, VECS[i].data);
      end
    end
    check("R2 pins bank0", pin_out[31:0], 32'hA5C3_120F);
    check("R11 pins bank1", pin_out[63:32], 32'hDEAD_BEEF);
    check("R4 oe bank2", pin_oe[95:64], 32'h00FF_0000);
    check("R4 oe bank0", pin_oe[31:0], 32'h0);

    // R5: two-stage synchroniser latency
    set_b3(32'h5A5A_0001);
    @(negedge clk); bus_read(6'h33, rd); check("R5 one edge", rd, 32'h0);
    @(negedge clk); bus_read(6'h33, rd); check("R5 two edges", rd, 32'h5A5A_0001);

    // R6: level, active high on pin 0
    bus_write(6'h39, 32'h1);
    bus_write(6'h36, 32'h1);
    bus_read(6'h3B, rd); check("R6 level set", rd & 32'h1, 32'h1);
    check("R9 irq level", {31'b0, irq}, 32'h1);
    bus_write(6'h3B, 32'h1);
    bus_read(6'h3B, rd); check("R6 w1c ignored", rd & 32'h1, 32'h1);
    set_b3(32'h5A5A_0000); cycles(3);
    bus_read(6'h3B, rd); check("R6 level gone", rd & 32'h1, 32'h0);
    check("R9 irq drops", {31'b0, irq}, 32'h0);

    // R7: rising edge on pin 1
    bus_write(6'h37, 32'h1);
    bus_write(6'h38, 32'h2);
    bus_write(6'h39, 32'h2);
    bus_write(6'h36, 32'h2);
    bus_read(6'h3B, rd); check("R7 idle", rd & 32'h2, 32'h0);
    set_b3(32'h5A5A_0002); cycles(4);
    bus_read(6'h3B, rd); check("R7 rise sets", rd & 32'h2, 32'h2);
    check("R9 irq edge", {31'b0, irq}, 32'h1);
    set_b3(32'h5A5A_0000); cycles(4);
    bus_read(6'h3B, rd); check("R7 sticky", rd & 32'h2, 32'h2);
    bus_write(6'h3B, 32'h2);
    bus_read(6'h3B, rd); check("R7 w1c", rd & 32'h2, 32'h0);
    check("R7 irq cleared", {31'b0, irq}, 32'h0);
    // R7: falling polarity
    bus_write(6'h39, 32'h0);
    set_b3(32'h5A5A_0002); cycles(4);
    bus_read(6'h3B, rd); check("R7 rise ignored", rd & 32'h2, 32'h0);
    set_b3(32'h5A5A_0000); cycles(4);
    bus_read(6'h3B, rd); check("R7 fall sets", rd & 32'h2, 32'h2);
    bus_write(6'h3B, 32'h2);

    // R8: both edges
    bus_write(6'h3A, 32'h2);
    set_b3(32'h5A5A_0002); cycles(4);
    bus_read(6'h3B, rd); check("R8 rise", rd & 32'h2, 32'h2);
    bus_write(6'h3B, 32'h2);
    bus_read(6'h3B, rd); check("R8 cleared", rd & 32'h2, 32'h0);
    set_b3(32'h5A5A_0000); cycles(4);
    bus_read(6'h3B, rd); check("R8 fall", rd & 32'h2, 32'h2);

    // R9: enable clear / set with status pending
    bus_write(6'h37, 32'h2);
    check("R9 disabled", {31'b0, irq}, 32'h0);
    bus_read(6'h36, rd); check("R9 enable readback", rd, 32'h0);
    bus_read(6'h3B, rd); check("R9 status kept", rd & 32'h2, 32'h2);
    bus_write(6'h36, 32'h2);
    check("R9 re-enabled", {31'b0, irq}, 32'h1);
    bus_write(6'h3B, 32'h2);
    check("R9 after clear", {31'b0, irq}, 32'h0);

    // R10: bypass on bank 0
    @(negedge clk) byp_in[31:0] = 32'h1357_2468;
    bus_write(6'h0C, 32'h1);
    check("R10 bypass out", pin_out[31:0], 32'h1357_2468);
    check("R10 other bank", pin_out[63:32], 32'hDEAD_BEEF);
    bus_read(6'h00, rd); check("R10 dout kept", rd, 32'hA5C3_120F);
    @(negedge clk) byp_in[31:0] = 32'h0F0F_0F0F;
    #1 check("R10 follows", pin_out[31:0], 32'h0F0F_0F0F);
    bus_write(6'h0C, 32'h0);
    check("R10 restored", pin_out[31:0], 32'hA5C3_120F);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule